// File: doc/BRIEF.md
# Serial-Addressed DAC Code Register Bank

This block receives 16-bit command words over a three-wire serial link (an active-low frame enable, a shift clock and a data line). It writes an 8-bit code from each word into one of twelve channel latches that feed external digital-to-analog converters. A 4-bit address field in the word picks the channel. Every latched code leaves the block on its own 8-bit slice of a parallel output bus.

The serial pins are asynchronous to the block's system clock. They pass through a synchronizer and are edge-detected in the system clock domain. A word takes effect only when the enable line returns high after at least sixteen shift-clock rising edges. If more than sixteen bits are shifted, the last sixteen are used. This lets a chain of devices share one frame. A serial output carries the oldest bit of the shift register and changes on the falling shift-clock edge, so the next device in the chain samples it on its own rising edge. A synchronous reset, or a separate power-on pulse, clears every code.

Top module: `sdac_regbank`

## Requirements
- R1: While `rst` is high at a system clock edge, every channel code and `ser_do` are zero after that edge.
- R2: A data bit is captured only on a rising edge of `ser_clk` while `ser_en_n` is low. The first bit shifted is the word's bit 15 (most significant first).
- R3: A rising edge of `ser_en_n` commits the word. Bits 3:0 are the address, bits 11:4 are the code and bits 15:12 are ignored. Address k, with k from 1 to 12, writes the code into channel k-1 (`code_o[8*(k-1)+7 : 8*(k-1)]`). No other channel changes.
- R4: A committed word whose address is 0, 13, 14 or 15 leaves every channel unchanged.
- R5: A frame with fewer than 16 rising edges of `ser_clk` leaves every channel unchanged.
- R6: A frame with more than 16 rising edges commits only the last 16 bits shifted.
- R7: Edges on `ser_clk` while `ser_en_n` is high do not alter the shift register, so `ser_do` keeps its value.
- R8: `ser_do` shows bit 15 of the shift register and updates only on falling edges of `ser_clk`. After the n-th rising edge of a frame (n ≥ 16), it carries the bit shifted in at edge n-15.
- R9: A pulse on `por` clears every channel code exactly as `rst` does.
- R10: A channel code holds its value in every cycle without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| por | input | 1 | Power-on reset pulse, ORed with `rst` |
| ser_clk | input | 1 | Serial shift clock |
| ser_en_n | input | 1 | Frame enable, active low |
| ser_di | input | 1 | Serial data in, MSB first |
| ser_do | output | 1 | Serial cascade output |
| code_o | output | 96 | Twelve 8-bit channel codes, channel 0 in bits 7:0 |

## Verification
Plain 16-bit frames are sent to the first channel, the last channel and a middle channel. The upper nibble is varied and asymmetric codes are used, so a wrong bit order, a misplaced field or a wrong channel decode each show up as a different mismatch. Frames with unused address codes, a 15-bit frame and a 32-bit frame separate the reject paths from the last-sixteen rule. The 32-bit frame also checks the delayed cascade output bit by bit. Shift-clock toggles with the enable high, followed by a power-on pulse, confirm that idle clocking is ignored and that both reset sources clear the bank.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
   localparam int unsigned DEF_FRAME_W = 16;
   localparam int unsigned DEF_ADDR_W  = 4;
   localparam int unsigned DEF_CODE_W  = 8;
   localparam int unsigned DEF_NCH     = 12;
   localparam int unsigned DEF_SYNC    = 2;

   // channel ch answers to address ch+1; address 0 is never a channel
   function automatic logic addr_selects(input int unsigned addr, input int unsigned ch);
      return addr == ch + 1;
   endfunction

   function automatic logic addr_valid(input int unsigned addr, input int unsigned nch);
      return (addr >= 1) && (addr <= nch);
   endfunction
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
`timescale 1ns/1ps
module sdac_edge #(
   parameter int unsigned W        = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= RST_VAL;
      else     prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/sdac_shifter.sv
`timescale 1ns/1ps
module sdac_shifter #(
   parameter int unsigned FW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          shift,
   input  logic          sdi,
   input  logic          out_stb,
   input  logic          finish,
   output logic [FW-1:0] word,
   output logic          commit,
   output logic          sdo
);
   localparam int unsigned CNTW = $clog2(FW + 1);
   localparam logic [CNTW-1:0] FULL = CNTW'(FW);

   logic [FW-1:0]   sreg;
   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg <= '0;
         cnt  <= '0;
         sdo  <= 1'b0;
      end else begin
         if (start) cnt <= '0;
         else if (shift && cnt != FULL) cnt <= cnt + 1'b1;
         if (shift) sreg <= {sreg[FW-2:0], sdi};
         if (out_stb) sdo <= sreg[FW-1];
      end
   end

   assign word   = sreg;
   assign commit = finish && (cnt == FULL);
endmodule

// File: rtl/sdac_latches.sv
`timescale 1ns/1ps
module sdac_latches
   import sdac_pkg::*;
#(
   parameter int unsigned AW  = 4,
   parameter int unsigned CW  = 8,
   parameter int unsigned NCH = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic [AW-1:0]     ld_addr,
   input  logic [CW-1:0]     ld_data,
   output logic [NCH*CW-1:0] code
);
   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic          hit;
      logic [CW-1:0] val;

      assign hit = ld && addr_selects(int'(ld_addr), ch);

      always_ff @(posedge clk) begin
         if (rst)      val <= '0;
         else if (hit) val <= ld_data;
      end

      assign code[ch*CW +: CW] = val;
   end
endmodule

// File: rtl/sdac_regbank.sv
`timescale 1ns/1ps
module sdac_regbank
   import sdac_pkg::*;
#(
   parameter int unsigned FW   = DEF_FRAME_W,
   parameter int unsigned AW   = DEF_ADDR_W,
   parameter int unsigned CW   = DEF_CODE_W,
   parameter int unsigned NCH  = DEF_NCH,
   parameter int unsigned SYNC = DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              por,
   input  logic              ser_clk,
   input  logic              ser_en_n,
   input  logic              ser_di,
   output logic              ser_do,
   output logic [NCH*CW-1:0] code_o
);
   localparam int unsigned DLSB = AW;

   if (NCH < 1 || NCH > (1 << AW) - 1) begin : g_bad_nch
      $error("channel count does not fit the address field");
   end
   if (AW + CW > FW) begin : g_bad_frame
      $error("address and code fields exceed the frame");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are needed");
   end

   logic          rst_any;
   logic [2:0]    pins_s;
   logic [1:0]    rise, fall;
   logic          en_active;
   logic          sclk_rise, sclk_fall, en_start, en_end;
   logic [FW-1:0] word;
   logic          ld_stb;
   logic [AW-1:0] ld_addr;
   logic [CW-1:0] ld_data;

   assign rst_any = rst | por;

   // bit 2: shift clock, bit 1: enable (idle high), bit 0: data
   sdac_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst(rst_any), .d({ser_clk, ser_en_n, ser_di}), .q(pins_s)
   );

   sdac_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
      .clk(clk), .rst(rst_any), .lvl(pins_s[2:1]), .rise(rise), .fall(fall)
   );

   assign sclk_rise = rise[1];
   assign sclk_fall = fall[1];
   assign en_end    = rise[0];
   assign en_start  = fall[0];
   assign en_active = ~pins_s[1];

   sdac_shifter #(.FW(FW)) u_shift (
      .clk(clk), .rst(rst_any),
      .start(en_start), .shift(sclk_rise && en_active), .sdi(pins_s[0]),
      .out_stb(sclk_fall), .finish(en_end),
      .word(word), .commit(ld_stb), .sdo(ser_do)
   );

   assign ld_addr = word[AW-1:0];
   assign ld_data = word[DLSB +: CW];

   sdac_latches #(.AW(AW), .CW(CW), .NCH(NCH)) u_bank (
      .clk(clk), .rst(rst_any), .ld(ld_stb),
      .ld_addr(ld_addr), .ld_data(ld_data), .code(code_o)
   );
endmodule

// File: rtl/sdac_regbank_chk.sv
`timescale 1ns/1ps
module sdac_regbank_chk
   import sdac_pkg::*;
#(
   parameter int unsigned AW  = 4,
   parameter int unsigned CW  = 8,
   parameter int unsigned NCH = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              por,
   input logic [NCH*CW-1:0] code_o,
   input logic              ser_do,
   input logic              ld_stb,
   input logic [AW-1:0]     ld_addr,
   input logic              sclk_fall
);
   logic [NCH*CW-1:0] prev_code;
   logic [NCH-1:0]    chg;

   always_ff @(posedge clk) prev_code <= code_o;

   for (genvar i = 0; i < NCH; i++) begin : g_chg
      assign chg[i] = code_o[i*CW +: CW] != prev_code[i*CW +: CW];
   end

   // R1 and R9: either reset source clears the bank and the cascade output
   a_r1_reset_clears: assert property (@(posedge clk)
      (rst || por) |=> (code_o == '0 && ser_do == 1'b0));

   // R10
   a_r10_hold: assert property (@(posedge clk) disable iff (rst || por)
      !ld_stb |=> $stable(code_o));

   // R4
   a_r4_bad_addr: assert property (@(posedge clk) disable iff (rst || por)
      (ld_stb && !addr_valid(int'(ld_addr), NCH)) |=> $stable(code_o));

   // R3
   a_r3_one_channel: assert property (@(posedge clk) disable iff (rst || por)
      ld_stb |=> ($countones(chg) <= 1));

   // R8
   a_r8_do_on_fall: assert property (@(posedge clk) disable iff (rst || por)
      !sclk_fall |=> $stable(ser_do));
endmodule

bind sdac_regbank sdac_regbank_chk #(.AW(AW), .CW(CW), .NCH(NCH)) u_chk (
   .clk(clk), .rst(rst), .por(por), .code_o(code_o), .ser_do(ser_do),
   .ld_stb(ld_stb), .ld_addr(ld_addr), .sclk_fall(sclk_fall)
);

// File: tb/sdac_regbank_bench.sv
`timescale 1ns/1ps
module sdac_regbank_bench;
   localparam int NCH = 12;
   localparam int CW  = 8;
   localparam int HP  = 8;

   logic clk = 1'b0;
   logic rst = 1'b1, por = 1'b0;
   logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_di = 1'b0;
   logic ser_do;
   logic [NCH*CW-1:0] code_o;

   int checks = 0, errors = 0;
   logic [CW-1:0] mdl [NCH];
   logic [NCH*CW-1:0] expq [$];
   string tagq [$];
   event snap_ev;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sdac_regbank u_sdac_regbank (
      .clk(clk), .rst(rst), .por(por), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
      .ser_di(ser_di), .ser_do(ser_do), .code_o(code_o)
   );

   task automatic check1(input string req, input logic [NCH*CW-1:0] act, input logic [NCH*CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [NCH*CW-1:0] pack_mdl();
      logic [NCH*CW-1:0] v;
      for (int i = 0; i < NCH; i++) v[i*CW +: CW] = mdl[i];
      return v;
   endfunction

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // shift n bits MSB first; optionally check the cascade output after each fall
   task automatic shift_bits(input logic [31:0] bits, input int n, input bit chk_do);
      ser_en_n = 1'b0;
      waitc(HP);
      for (int j = 0; j <= n; j++) begin
         ser_clk = 1'b0;
         if (j < n) ser_di = bits[n-1-j];
         waitc(HP);
         if (chk_do && j >= 16) begin
            checks++;
            if (ser_do !== bits[n-1-(j-16)]) begin
               errors++;
               $display("FAIL R8 edge %0d actual=%b expected=%b", j, ser_do, bits[n-1-(j-16)]);
            end
         end
         if (j < n) begin
            ser_clk = 1'b1;
            waitc(HP);
         end
      end
      ser_en_n = 1'b1;
      waitc(12);
   endtask

   // driver: updates the model and queues the expected bank
   task automatic push_expect(input string tag);
      expq.push_back(pack_mdl());
      tagq.push_back(tag);
      -> snap_ev;
      waitc(1);
   endtask

   task automatic frame(input logic [3:0] top, input logic [3:0] addr, input logic [7:0] c, input string tag);
      shift_bits({16'h0, top, c, addr}, 16, 1'b0);
      if (addr >= 1 && addr <= NCH) mdl[addr-1] = c;
      push_expect(tag);
   endtask

   // monitor: compares the design's bank against each queued expectation
   initial begin
      forever begin
         @(snap_ev);
         while (expq.size() > 0) check1(tagq.pop_front(), code_o, expq.pop_front());
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) mdl[i] = '0;
      waitc(5);
      rst = 1'b0;
      waitc(2);
      // R1
      push_expect("R1 reset codes");
      check1("R1 reset ser_do", {95'b0, ser_do}, '0);

      // R2 R3: MSB-first, field placement, first/last/middle channels
      frame(4'h0, 4'd1,  8'hA5, "R2 R3 ch0");
      frame(4'hF, 4'd12, 8'h3C, "R3 ch11 upper nibble ignored");
      frame(4'h9, 4'd7,  8'hFF, "R3 ch6");
      frame(4'h6, 4'd7,  8'h01, "R3 ch6 overwrite");

      // R4
      frame(4'h0, 4'd0,  8'h77, "R4 addr0");
      frame(4'h3, 4'd13, 8'h55, "R4 addr13");
      frame(4'hF, 4'd15, 8'hEE, "R4 addr15");

      // R5: 15 bits only (would target channel 1)
      shift_bits({17'h0, 15'h0C2}, 15, 1'b0);
      push_expect("R5 short frame");

      // R6 R8: 32 bits, only the second word lands; cascade checked per edge
      shift_bits({4'h0, 8'h11, 4'd3, 4'h0, 8'h62, 4'd4}, 32, 1'b1);
      mdl[3] = 8'h62;
      push_expect("R6 last sixteen bits");

      // R7: shift clock toggles while enable is high; word was 0x0624, bit15=0, bit10=1
      ser_di = 1'b1;
      for (int k = 0; k < 5; k++) begin
         ser_clk = 1'b1; waitc(HP);
         ser_clk = 1'b0; waitc(HP);
      end
      check1("R7 ser_do idle clocks", {95'b0, ser_do}, '0);
      push_expect("R7 codes idle clocks");

      // R10: hold across a long quiet stretch
      waitc(200);
      push_expect("R10 hold");

      // R9
      por = 1'b1; waitc(1); por = 1'b0; waitc(2);
      for (int i = 0; i < NCH; i++) mdl[i] = '0;
      push_expect("R9 power-on clear");

      // R1 again after reload
      frame(4'h2, 4'd5, 8'h9A, "R3 ch4 after por");
      rst = 1'b1; waitc(1); rst = 1'b0; waitc(2);
      for (int i = 0; i < NCH; i++) mdl[i] = '0;
      push_expect("R1 reset after load");

      waitc(4);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule